// File: doc/BRIEF.md
# Add-With-Carry Flags and Condition Check Unit

This combinational unit serves an integer execute stage. It does two jobs. The first is a wide add with carry. It takes two operands and a carry-in bit, and it returns the sum together with four flags: negative, zero, carry and signed overflow. To subtract, the caller inverts the second operand and sets carry-in to one. Inside the unit the adder is a chain of narrow lanes, and each lane passes its carry to the next.

The second job is to decide whether a conditional instruction executes. It takes a 4-bit condition code and the current negative, zero, carry and overflow flags. Bits [3:1] of the code pick a flag test. Bit 0 inverts the result of that test. The one exception is the all-pass selector, which bit 0 never inverts. A small decoder turns the code into one-hot select strobes plus an invert strobe. The datapath then combines those strobes with the flag tests.

The two parts share no state. The flag inputs of the condition checker are independent ports. They are not wired to the adder outputs.

Top module: `adc_cond_unit`

## Requirements
- R1: `sum` equals `opA + opB + carryIn` modulo 2^32.
- R2: `carryOut` is 1 exactly when the unsigned value of `opA + opB + carryIn` is 2^32 or greater.
- R3: `overflow` is 1 exactly when the signed sum of `opA`, `opB` and `carryIn` lies outside the range -2^31 to 2^31-1.
- R4: `sumN` equals `sum[31]`. `sumZ` is 1 exactly when all 32 bits of `sum` are zero.
- R5: With `cond[0]`=0, selectors `cond[3:1]` 0, 1, 2 and 3 pass when Z, C, N or V is set, in that order.
- R6: With `cond[0]`=0, selector 4 passes when C=1 and Z=0. Selector 5 passes when N equals V. Selector 6 passes when N equals V and Z=0.
- R7: For selectors 0 to 6, `cond[0]`=1 gives the inverse of the R5/R6 test.
- R8: Selector 7 passes for any flag values, for both code 4'b1110 and code 4'b1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First addend |
| opB | input | 32 | Second addend (inverted by the caller to subtract) |
| carryIn | input | 1 | Carry into bit 0 |
| cond | input | 4 | Condition code: [3:1] selector, [0] invert |
| flagN | input | 1 | Current negative flag |
| flagZ | input | 1 | Current zero flag |
| flagC | input | 1 | Current carry flag |
| flagV | input | 1 | Current overflow flag |
| sum | output | 32 | Sum, modulo 2^32 |
| sumN | output | 1 | Negative flag of the sum |
| sumZ | output | 1 | Zero flag of the sum |
| carryOut | output | 1 | Unsigned carry out |
| overflow | output | 1 | Signed overflow |
| condPass | output | 1 | Condition passes |

## Verification
The hardest adder cases are those where a carry ripples through every lane boundary. One example is all-ones plus all-ones with carry-in set. Another is the move from 0x7FFFFFFF to 0x80000000, where signed overflow must appear without an unsigned carry. Operands 0x80000000 plus 0x80000000 set both flags while the zero flag is also set. The table drives each of these cases explicitly. For the condition checker, the rare case is code 4'b1111, where a plain invert rule would give never-pass. The bench sweeps all 16 codes against all 16 flag combinations so that both all-pass codes are reached with every flag pattern.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;

  localparam int SEL_COUNT = 8;

  typedef struct packed {
    logic [SEL_COUNT-1:0] testSel;  // one-hot flag-test select
    logic                 invert;   // invert the selected test
  } condStrobe_t;

endpackage

// File: rtl/adc_cond_ctrl.sv
module adc_cond_ctrl
  import adc_cond_pkg::*;
(
  input  logic [3:0]  cond,
  output condStrobe_t strobe
);

  localparam logic [2:0] SEL_ALWAYS = 3'd7;

  logic [2:0] selector;

  always_comb begin
    selector       = cond[3:1];
    strobe.testSel = '0;
    strobe.testSel[selector] = 1'b1;
    strobe.invert  = cond[0] & (selector != SEL_ALWAYS);
  end

  // R5
  always_comb begin
    one_hot_sel_chk: assert ($countones(strobe.testSel) == 1)
      else $error("select strobe not one-hot");
  end

endmodule

// File: rtl/adc_cond_dpath.sv
module adc_cond_dpath
  import adc_cond_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int LANE_W = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  condStrobe_t      strobe,
  input  logic             flagN,
  input  logic             flagZ,
  input  logic             flagC,
  input  logic             flagV,
  output logic [WIDTH-1:0] sum,
  output logic             sumN,
  output logic             sumZ,
  output logic             carryOut,
  output logic             overflow,
  output logic             condPass
);

  localparam int LANES = WIDTH / LANE_W;
  localparam int MSB   = WIDTH - 1;

  logic [LANES:0] laneCarry;

  assign laneCarry[0] = carryIn;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W:0] laneSum;
    assign laneSum = {1'b0, opA[g*LANE_W +: LANE_W]}
                   + {1'b0, opB[g*LANE_W +: LANE_W]}
                   + (LANE_W+1)'(laneCarry[g]);
    assign sum[g*LANE_W +: LANE_W] = laneSum[LANE_W-1:0];
    assign laneCarry[g+1]          = laneSum[LANE_W];
  end

  assign carryOut = laneCarry[LANES];
  assign overflow = (opA[MSB] == opB[MSB]) && (sum[MSB] != opA[MSB]);
  assign sumN     = sum[MSB];
  assign sumZ     = ~|sum;

  logic [SEL_COUNT-1:0] flagTests;
  logic                 nEqV;
  logic                 rawPass;

  always_comb begin
    nEqV      = (flagN == flagV);
    flagTests = {1'b1, nEqV & ~flagZ, nEqV, flagC & ~flagZ,
                 flagV, flagN, flagC, flagZ};
    rawPass   = |(strobe.testSel & flagTests);
    condPass  = rawPass ^ strobe.invert;
  end

  // R1 R2
  always_comb begin
    carry_sum_chk: assert ({carryOut, sum} ==
        ({1'b0, opA} + {1'b0, opB} + (WIDTH+1)'(carryIn)))
      else $error("sum/carry mismatch");
  end

  // R3
  always_comb begin
    signed_ovf_chk: assert (overflow ==
        (($signed({opA[MSB], opA}) + $signed({opB[MSB], opB})
          + $signed({{WIDTH{1'b0}}, carryIn}))
         != $signed({sum[MSB], sum})))
      else $error("overflow mismatch");
  end

endmodule

// File: rtl/adc_cond_unit.sv
module adc_cond_unit
  import adc_cond_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int LANE_W = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [3:0]       cond,
  input  logic             flagN,
  input  logic             flagZ,
  input  logic             flagC,
  input  logic             flagV,
  output logic [WIDTH-1:0] sum,
  output logic             sumN,
  output logic             sumZ,
  output logic             carryOut,
  output logic             overflow,
  output logic             condPass
);

  condStrobe_t strobe;

  adc_cond_ctrl uCtrl (
    .cond   (cond),
    .strobe (strobe)
  );

  adc_cond_dpath #(.WIDTH(WIDTH), .LANE_W(LANE_W)) uDpath (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .strobe   (strobe),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .flagV    (flagV),
    .sum      (sum),
    .sumN     (sumN),
    .sumZ     (sumZ),
    .carryOut (carryOut),
    .overflow (overflow),
    .condPass (condPass)
  );

  // R8
  always_comb begin
    always_pass_chk: assert (!(cond[3:1] == 3'b111) || condPass)
      else $error("selector 7 did not pass");
  end

endmodule

// File: tb/adc_cond_unit_test.sv
module adc_cond_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA, opB;
  logic        carryIn;
  logic [3:0]  cond;
  logic        flagN, flagZ, flagC, flagV;
  logic [31:0] sum;
  logic        sumN, sumZ, carryOut, overflow, condPass;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  adc_cond_unit uut (
    .opA(opA), .opB(opB), .carryIn(carryIn), .cond(cond),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .sum(sum), .sumN(sumN), .sumZ(sumZ), .carryOut(carryOut),
    .overflow(overflow), .condPass(condPass)
  );

  // {a, b, cin, expSum, expCarry, expOvf}
  localparam int NVEC = 8;
  localparam logic [98:0] VEC [NVEC] = '{
    {32'h0000_0001, 32'h0000_0001, 1'b0, 32'h0000_0002, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0, 1'b1},
    {32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 1'b1},
    {32'h0000_0005, 32'hFFFF_FFFC, 1'b1, 32'h0000_0002, 1'b1, 1'b0},
    {32'h0000_0003, 32'hFFFF_FFFA, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {32'h8000_0000, 32'hFFFF_FFFE, 1'b1, 32'h7FFF_FFFF, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit expectPass(input logic [3:0] c, input logic n,
                                    input logic z, input logic cy,
                                    input logic v);
    bit t;
    case (c[3:1])
      3'd0: t = z;
      3'd1: t = cy;
      3'd2: t = n;
      3'd3: t = v;
      3'd4: t = cy && !z;
      3'd5: t = (n == v);
      3'd6: t = (n == v) && !z;
      default: return 1'b1;
    endcase
    return c[0] ? !t : t;
  endfunction

  function automatic string condReq(input logic [3:0] c);
    if (c[3:1] == 3'd7) return "R8";
    if (c[0])           return "R7";
    if (c[3:1] >= 3'd4) return "R6";
    return "R5";
  endfunction

  initial begin
    opA = '0; opB = '0; carryIn = 1'b0; cond = 4'd0;
    flagN = 0; flagZ = 0; flagC = 0; flagV = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #2;
    // reset state: all-zero inputs
    check(sum == 32'd0, "R1 reset sum", sum, 32'd0);
    check(sumZ == 1'b1, "R4 reset zero", 32'(sumZ), 32'd1);
    check(condPass == 1'b0, "R5 reset cond", 32'(condPass), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      opA = VEC[i][98:67]; opB = VEC[i][66:35]; carryIn = VEC[i][34];
      #2;
      check(sum == VEC[i][33:2], "R1 sum", sum, VEC[i][33:2]);
      check(carryOut == VEC[i][1], "R2 carry", 32'(carryOut), 32'(VEC[i][1]));
      check(overflow == VEC[i][0], "R3 overflow", 32'(overflow), 32'(VEC[i][0]));
      check(sumN == VEC[i][33], "R4 negative", 32'(sumN), 32'(VEC[i][33]));
      check(sumZ == (VEC[i][33:2] == 32'd0), "R4 zero", 32'(sumZ),
            32'(VEC[i][33:2] == 32'd0));
    end

    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        @(negedge clk);
        cond = 4'(c);
        {flagN, flagZ, flagC, flagV} = 4'(f);
        #2;
        check(condPass == expectPass(4'(c), f[3], f[2], f[1], f[0]),
              condReq(4'(c)), 32'(condPass),
              32'(expectPass(4'(c), f[3], f[2], f[1], f[0])));
      end
    end

    // directed: code 1111 with all flags clear and all flags set (R8)
    @(negedge clk);
    cond = 4'b1111; {flagN, flagZ, flagC, flagV} = 4'b0000;
    #2;
    check(condPass == 1'b1, "R8 code 1111 flags clear", 32'(condPass), 32'd1);
    @(negedge clk);
    {flagN, flagZ, flagC, flagV} = 4'b1111;
    #2;
    check(condPass == 1'b1, "R8 code 1111 flags set", 32'(condPass), 32'd1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule